// File: doc/BRIEF.md
# Power-Up Coefficient Loader

This block fills a 32-bit coefficient RAM from a paged 16-bit flash array once reset is released. It first reads a marker word at the start of the custom region, which is page two at flash word 200h. If that marker is nonzero, the custom pages two and three are copied. If it is zero, the default pages zero and one are copied. Each RAM word is assembled from two adjacent flash words. The RAM holds four channels of 64 words each. In the flash, one channel's pairs are spaced 80h words from the next channel's; in the RAM, channels are spaced 40h words apart.

While the copy runs, the block asserts a busy flag. During that time it also guards its host-facing register interface:
- a flash data-in register, which accepts writes only while idle;
- a flash data-out register, filled by host flash reads and flagged valid only while idle;
- a host write path into the coefficient RAM, which is held off (not granted) until loading finishes.

Top module: `coef_loader`

## Requirements
- R1: The first flash access after reset release is a read of address 200h (the custom-set marker), issued in the first clock cycle after reset release.
- R2: If the marker word is nonzero, all coefficient reads use addresses 200h–3FFh. If it is zero, all coefficient reads use 000h–1FFh. In both cases, bit 9 of the flash address is the set select.
- R3: Every 32-bit RAM word equals {flash[a], flash[a+1]}, where a is even: the lower address gives bits 31:16 and the next address gives bits 15:0. The flash read data arrives one clock after the read request.
- R4: RAM word {ch, idx} (ch = bits 7:6, idx = bits 5:0) is loaded from flash pair address set_base + ch·80h + 2·idx. RAM words are written in ascending address order from 00h to FFh.
- R5: `busy_o` is 1 during reset and stays 1 until the 256th RAM write, which comes 770 cycles after reset release. Busy never reasserts without a reset.
- R6: `done_o` pulses for exactly one cycle, in the cycle in which `busy_o` first reads 0.
- R7: The flash data-in register resets to 0000h. A write to it while busy is ignored. A write while idle appears on `flash_din_o` after the next clock edge.
- R8: `dout_valid_o` is 1 exactly when not busy. A host flash read issued while idle loads the addressed flash word into `dout_o`, visible two clock edges after the request.
- R9: While busy, host RAM requests receive no grant and do not reach the RAM port. While idle, a request is granted in the same cycle and drives `ram_we_o`, `ram_addr_o` and `ram_wdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_addr_o | output | 11 | Flash word address |
| flash_rdata_i | input | 16 | Flash read data, one cycle after the strobe |
| ram_we_o | output | 1 | Coefficient RAM write enable |
| ram_addr_o | output | 8 | Coefficient RAM address |
| ram_wdata_o | output | 32 | Coefficient RAM write data |
| host_din_we_i | input | 1 | Host write to the flash data-in register |
| host_din_i | input | 16 | Host data for the flash data-in register |
| flash_din_o | output | 16 | Flash data-in register contents |
| host_frd_i | input | 1 | Host flash read request |
| host_faddr_i | input | 11 | Host flash read address |
| dout_o | output | 16 | Flash data-out register |
| dout_valid_o | output | 1 | Data-out register is valid |
| host_ram_req_i | input | 1 | Host RAM write request |
| host_ram_addr_i | input | 8 | Host RAM write address |
| host_ram_wdata_i | input | 32 | Host RAM write data |
| host_ram_gnt_o | output | 1 | Host RAM request granted |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse when loading ends |

## Verification
The hardest situation to reach is host traffic landing in the middle of the copy. Host writes, flash reads and RAM requests must be refused without disturbing a RAM word that is half assembled. The stimulus fires all three host requests about fifty cycles into the load. The reference model then checks every later sequencer write and confirms that the data-in register kept its reset value. The marker decision is covered by two runs over the same array, one with a zero marker and one with a nonzero marker. The two sets hold different data, so reading from the wrong set shows up as a data mismatch on every word.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
  typedef enum logic [2:0] {
    ST_MARK_RD,
    ST_MARK_CHK,
    ST_HI,
    ST_LO,
    ST_WR,
    ST_IDLE
  } ld_state_e;
endpackage

// File: rtl/coef_seq.sv
module coef_seq
  import coef_loader_pkg::*;
#(
  parameter int FLASH_AW = 11,
  parameter int DATA_W   = 16,
  parameter int CH_N     = 4,
  parameter int WPC      = 64,
  parameter int PAGE_W   = 256,
  localparam int IDX_W   = $clog2(WPC),
  localparam int CH_W    = $clog2(CH_N),
  localparam int RAM_AW  = CH_W + IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   flash_rdata_i,
  output logic                seq_rd_o,
  output logic [FLASH_AW-1:0] seq_addr_o,
  output logic                seq_we_o,
  output logic [RAM_AW-1:0]   seq_waddr_o,
  output logic [2*DATA_W-1:0] seq_wdata_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int CUSTOM_OFS = 2 * PAGE_W;
  localparam int CH_SH      = $clog2(2 * WPC);
  localparam logic [RAM_AW-1:0] LAST = RAM_AW'(CH_N * WPC - 1);

  ld_state_e           state_q;
  logic [RAM_AW-1:0]   cnt_q;
  logic                custom_q;
  logic [DATA_W-1:0]   hi_q;
  logic                busy_q, done_q;
  logic [FLASH_AW-1:0] base_w, pair_w;
  logic [CH_W-1:0]     ch_w;
  logic [IDX_W-1:0]    idx_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_MARK_RD;
      cnt_q    <= '0;
      custom_q <= 1'b0;
      hi_q     <= '0;
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_MARK_RD:  state_q <= ST_MARK_CHK;
        ST_MARK_CHK: begin
          custom_q <= |flash_rdata_i;
          state_q  <= ST_HI;
        end
        ST_HI: state_q <= ST_LO;
        ST_LO: begin
          hi_q    <= flash_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_HI;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ch_w   = cnt_q[RAM_AW-1:IDX_W];
  assign idx_w  = cnt_q[IDX_W-1:0];
  assign base_w = custom_q ? FLASH_AW'(CUSTOM_OFS) : '0;
  assign pair_w = base_w + (FLASH_AW'(ch_w) << CH_SH) + (FLASH_AW'(idx_w) << 1);

  always_comb begin
    seq_rd_o   = 1'b0;
    seq_addr_o = '0;
    unique case (state_q)
      ST_MARK_RD: begin seq_rd_o = 1'b1; seq_addr_o = FLASH_AW'(CUSTOM_OFS); end
      ST_HI:      begin seq_rd_o = 1'b1; seq_addr_o = pair_w; end
      ST_LO:      begin seq_rd_o = 1'b1; seq_addr_o = pair_w + 1'b1; end
      default:    ;
    endcase
  end

  assign seq_we_o    = (state_q == ST_WR);
  assign seq_waddr_o = cnt_q;
  assign seq_wdata_o = {hi_q, flash_rdata_i};
  assign busy_o      = busy_q;
  assign done_o      = done_q;
endmodule

// File: rtl/coef_host_if.sv
module coef_host_if #(
  parameter int FLASH_AW = 11,
  parameter int DATA_W   = 16,
  parameter int RAM_AW   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic                seq_rd_i,
  input  logic [FLASH_AW-1:0] seq_addr_i,
  input  logic                seq_we_i,
  input  logic [RAM_AW-1:0]   seq_waddr_i,
  input  logic [2*DATA_W-1:0] seq_wdata_i,
  input  logic [DATA_W-1:0]   flash_rdata_i,
  output logic                flash_rd_o,
  output logic [FLASH_AW-1:0] flash_addr_o,
  output logic                ram_we_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic [2*DATA_W-1:0] ram_wdata_o,
  input  logic                host_din_we_i,
  input  logic [DATA_W-1:0]   host_din_i,
  output logic [DATA_W-1:0]   flash_din_o,
  input  logic                host_frd_i,
  input  logic [FLASH_AW-1:0] host_faddr_i,
  output logic [DATA_W-1:0]   dout_o,
  output logic                dout_valid_o,
  input  logic                host_ram_req_i,
  input  logic [RAM_AW-1:0]   host_ram_addr_i,
  input  logic [2*DATA_W-1:0] host_ram_wdata_i,
  output logic                host_ram_gnt_o
);
  logic [DATA_W-1:0] din_q, dout_q;
  logic              rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q     <= '0;
      dout_q    <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      if (host_din_we_i && !busy_i) din_q <= host_din_i;
      rd_pend_q <= host_frd_i && !busy_i;
      if (rd_pend_q) dout_q <= flash_rdata_i;
    end
  end

  // sequencer owns both memory ports while loading
  assign flash_rd_o     = busy_i ? seq_rd_i   : host_frd_i;
  assign flash_addr_o   = busy_i ? seq_addr_i : host_faddr_i;
  assign host_ram_gnt_o = host_ram_req_i && !busy_i;
  assign ram_we_o       = busy_i ? seq_we_i    : host_ram_req_i;
  assign ram_addr_o     = busy_i ? seq_waddr_i : host_ram_addr_i;
  assign ram_wdata_o    = busy_i ? seq_wdata_i : host_ram_wdata_i;

  assign flash_din_o  = din_q;
  assign dout_o       = dout_q;
  assign dout_valid_o = !busy_i;
endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
  parameter int FLASH_AW = 11,
  parameter int DATA_W   = 16,
  parameter int CH_N     = 4,
  parameter int WPC      = 64,
  parameter int PAGE_W   = 256,
  localparam int RAM_AW  = $clog2(CH_N) + $clog2(WPC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                flash_rd_o,
  output logic [FLASH_AW-1:0] flash_addr_o,
  input  logic [DATA_W-1:0]   flash_rdata_i,
  output logic                ram_we_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic [2*DATA_W-1:0] ram_wdata_o,
  input  logic                host_din_we_i,
  input  logic [DATA_W-1:0]   host_din_i,
  output logic [DATA_W-1:0]   flash_din_o,
  input  logic                host_frd_i,
  input  logic [FLASH_AW-1:0] host_faddr_i,
  output logic [DATA_W-1:0]   dout_o,
  output logic                dout_valid_o,
  input  logic                host_ram_req_i,
  input  logic [RAM_AW-1:0]   host_ram_addr_i,
  input  logic [2*DATA_W-1:0] host_ram_wdata_i,
  output logic                host_ram_gnt_o,
  output logic                busy_o,
  output logic                done_o
);
  logic                seq_rd, seq_we;
  logic [FLASH_AW-1:0] seq_addr;
  logic [RAM_AW-1:0]   seq_waddr;
  logic [2*DATA_W-1:0] seq_wdata;

  coef_seq #(
    .FLASH_AW(FLASH_AW), .DATA_W(DATA_W), .CH_N(CH_N), .WPC(WPC), .PAGE_W(PAGE_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flash_rdata_i(flash_rdata_i),
    .seq_rd_o     (seq_rd),
    .seq_addr_o   (seq_addr),
    .seq_we_o     (seq_we),
    .seq_waddr_o  (seq_waddr),
    .seq_wdata_o  (seq_wdata),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  coef_host_if #(
    .FLASH_AW(FLASH_AW), .DATA_W(DATA_W), .RAM_AW(RAM_AW)
  ) u_host (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .busy_i          (busy_o),
    .seq_rd_i        (seq_rd),
    .seq_addr_i      (seq_addr),
    .seq_we_i        (seq_we),
    .seq_waddr_i     (seq_waddr),
    .seq_wdata_i     (seq_wdata),
    .flash_rdata_i   (flash_rdata_i),
    .flash_rd_o      (flash_rd_o),
    .flash_addr_o    (flash_addr_o),
    .ram_we_o        (ram_we_o),
    .ram_addr_o      (ram_addr_o),
    .ram_wdata_o     (ram_wdata_o),
    .host_din_we_i   (host_din_we_i),
    .host_din_i      (host_din_i),
    .flash_din_o     (flash_din_o),
    .host_frd_i      (host_frd_i),
    .host_faddr_i    (host_faddr_i),
    .dout_o          (dout_o),
    .dout_valid_o    (dout_valid_o),
    .host_ram_req_i  (host_ram_req_i),
    .host_ram_addr_i (host_ram_addr_i),
    .host_ram_wdata_i(host_ram_wdata_i),
    .host_ram_gnt_o  (host_ram_gnt_o)
  );
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              flash_rd_o,
  input logic              ram_we_o,
  input logic              host_ram_gnt_o,
  input logic [DATA_W-1:0] flash_din_o
);
  a_r6_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r6_done_on_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_busy_no_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);
  a_r9_no_grant_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !host_ram_gnt_o);
  a_r7_din_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(flash_din_o));
  a_r3_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && busy_o) |-> $past(flash_rd_o));
endmodule

bind coef_loader coef_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .flash_rd_o    (flash_rd_o),
  .ram_we_o      (ram_we_o),
  .host_ram_gnt_o(host_ram_gnt_o),
  .flash_din_o   (flash_din_o)
);

// File: tb/coef_loader_tb_top.sv
`timescale 1ns/1ps
module coef_loader_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flash_rd_o;
  logic [10:0] flash_addr_o;
  logic [15:0] flash_rdata_i = '0;
  logic        ram_we_o;
  logic [7:0]  ram_addr_o;
  logic [31:0] ram_wdata_o;
  logic        host_din_we_i = 1'b0;
  logic [15:0] host_din_i = '0;
  logic [15:0] flash_din_o;
  logic        host_frd_i = 1'b0;
  logic [10:0] host_faddr_i = '0;
  logic [15:0] dout_o;
  logic        dout_valid_o;
  logic        host_ram_req_i = 1'b0;
  logic [7:0]  host_ram_addr_i = '0;
  logic [31:0] host_ram_wdata_i = '0;
  logic        host_ram_gnt_o;
  logic        busy_o, done_o;

  always #5 clk_i = ~clk_i;

  coef_loader dut_i (.*);

  logic [15:0] fmem [2048];
  always @(posedge clk_i) if (flash_rd_o) flash_rdata_i <= fmem[flash_addr_o];

  int errors = 0, checks = 0;
  logic [39:0] exp_q[$];
  int busy_cyc, wr_cnt, done_cnt;
  bit mon_on = 1'b0, finished = 1'b0, exp_custom;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] marker);
    for (int a = 0; a < 2048; a++) fmem[a] = 16'((a * 40503 + 4099) ^ (a >> 3));
    fmem[512] = marker;
    exp_custom = (marker != 0);
    exp_q.delete();
    for (int w = 0; w < 256; w++) begin
      int fa;
      fa = (exp_custom ? 512 : 0) + (w / 64) * 128 + (w % 64) * 2;
      exp_q.push_back({8'(w), fmem[fa], fmem[fa + 1]});
    end
    busy_cyc = 0; wr_cnt = 0; done_cnt = 0;
  endtask

  // reference comparison on every clock while a load is observed
  always @(negedge clk_i) if (mon_on && rst_ni) begin
    if (busy_o) begin
      if (busy_cyc == 0)
        chk(flash_rd_o && flash_addr_o == 11'h200, "R1", {flash_rd_o, flash_addr_o}, {1'b1, 11'h200});
      if (busy_cyc == 2)
        chk(flash_rd_o && flash_addr_o[9] == exp_custom, "R2", flash_addr_o[9], exp_custom);
      busy_cyc++;
      if (ram_we_o) begin
        logic [39:0] e;
        wr_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R5", wr_cnt, 256);
        else begin
          e = exp_q.pop_front();
          chk(ram_addr_o == e[39:32], "R4", ram_addr_o, e[39:32]);
          chk(ram_wdata_o == e[31:0], "R3", ram_wdata_o, e[31:0]);
        end
      end
    end
    if (done_o) begin
      done_cnt++;
      chk(!busy_o, "R6", busy_o, 0);
      chk(wr_cnt == 256, "R5", wr_cnt, 256);
      chk(busy_cyc == 770, "R5", busy_cyc, 770);
    end
  end

  task automatic run_load(input logic [15:0] marker);
    rst_ni = 1'b0;
    fill(marker);
    mon_on = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(busy_o && !done_o && flash_din_o == 0 && !dout_valid_o, "R5",
        {busy_o, done_o, flash_din_o, dout_valid_o}, {1'b1, 1'b0, 16'h0, 1'b0});
    rst_ni = 1'b1;
    repeat (50) @(negedge clk_i);
    // host traffic in the middle of the load
    host_din_we_i = 1'b1; host_din_i = 16'hBEEF;
    host_frd_i = 1'b1; host_faddr_i = 11'h77;
    host_ram_req_i = 1'b1; host_ram_addr_i = 8'h05; host_ram_wdata_i = 32'hDEAD_0000;
    #1 chk(!host_ram_gnt_o, "R9", host_ram_gnt_o, 0);
    @(negedge clk_i);
    host_din_we_i = 1'b0; host_frd_i = 1'b0; host_ram_req_i = 1'b0;
    chk(flash_din_o == 16'h0, "R7", flash_din_o, 16'h0);
    chk(!dout_valid_o, "R8", dout_valid_o, 0);
    repeat (2) @(negedge clk_i);
    chk(dout_o == 16'h0, "R8", dout_o, 16'h0);
    while (done_cnt == 0) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_cnt == 1 && !done_o, "R6", done_cnt, 1);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    mon_on = 1'b0;
  endtask

  task automatic idle_host;
    chk(dout_valid_o, "R8", dout_valid_o, 1);
    host_din_we_i = 1'b1; host_din_i = 16'h1234;
    @(negedge clk_i);
    host_din_we_i = 1'b0;
    chk(flash_din_o == 16'h1234, "R7", flash_din_o, 16'h1234);
    host_frd_i = 1'b1; host_faddr_i = 11'h123;
    @(negedge clk_i);
    host_frd_i = 1'b0;
    @(negedge clk_i);
    chk(dout_o == fmem[11'h123], "R8", dout_o, fmem[11'h123]);
    host_ram_req_i = 1'b1; host_ram_addr_i = 8'h55; host_ram_wdata_i = 32'hCAFE_F00D;
    #1 chk(host_ram_gnt_o && ram_we_o && ram_addr_o == 8'h55 && ram_wdata_o == 32'hCAFE_F00D,
           "R9", {host_ram_gnt_o, ram_we_o, ram_addr_o, ram_wdata_o},
           {1'b1, 1'b1, 8'h55, 32'hCAFE_F00D});
    @(negedge clk_i);
    host_ram_req_i = 1'b0;
    chk(!busy_o, "R5", busy_o, 0);
  endtask

  initial begin
    run_load(16'h0000);
    idle_host();
    run_load(16'h8001);
    idle_host();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R5: watchdog expired actual=busy expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule